// File: doc/BRIEF.md
# Serial Framed Word Parity Indicator

The block takes a serial bit stream on one input pin, one bit per clock cycle. It treats the stream as back-to-back words of a fixed length, counting cycles from reset. On the clock cycle that carries the last bit of each word, it reports that word's parity. Parity is 1 for an odd number of ones and 0 for an even number. The result is a Mealy output: the incoming bit is combined in the same cycle with a stored running-parity flag. A valid strobe marks that cycle. The parity output is held at 0 on every other cycle.

Framing is by cycle count only. The block does not detect a start or sync pattern. The word length is the parameter `WORD_LEN`, which must be a power of two. It is 4 by default, and 8 is the supported alternative.

Inside, a position counter of `log2(WORD_LEN)` flip-flops steps through the Gray code sequence regardless of the data. A two-state branch machine tracks the parity. The machine has two states:
- `BR_EVEN`: the bits seen so far in the word hold an even number of ones.
- `BR_ODD`: the bits seen so far hold an odd number of ones.

The machine moves between these states as follows:
- On a non-final cycle, an incoming 1 moves it to the other branch.
- On a non-final cycle, an incoming 0 keeps it on the same branch.
- On the final cycle, it always returns to `BR_EVEN`, whatever the input bit.

The counter also wraps to its initial code on the final cycle. The whole machine is therefore back in its initial state for the first bit of the next word.

Top module: `wpi_serial_parity`

## Requirements
- R1: While `rst_i` is held high across at least one clock edge, `valid_o` and `parity_o` read 0.
- R1: The first bit sampled after reset is bit 1 of a word.
- R2: `valid_o` is 1 on exactly one cycle of every `WORD_LEN` consecutive cycles: the cycle that carries bit number `WORD_LEN` of a word. It is 0 on all other cycles.
- R3: On a cycle where `valid_o` is 1, `parity_o` equals the XOR of all `WORD_LEN` bits of the word, including the bit present in that same cycle. The value is 1 for an odd number of ones and 0 for an even number.
- R4: On any cycle where `valid_o` is 0, `parity_o` is 0.
- R5: Words follow one another with no gap. The parity of one word has no effect on the result for the next word.
- R6: The position counter changes exactly one bit per clock, stepping in Gray order. Its progress, and hence the timing of `valid_o`, does not depend on the data.
- R7: The result depends only on the number of ones in a word, not on their positions.
- R8: With `WORD_LEN` = 8, R2 to R5 hold with an 8-cycle period.
- R9: A reset asserted in the middle of a word discards that partial word. Framing restarts with the next bit as bit 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; every bit is sampled on its rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| bit_i | input | 1 | Serial data, one bit per cycle |
| parity_o | output | 1 | Word parity in the final bit cycle, else 0 |
| valid_o | output | 1 | High during the final bit cycle of each word |

## Verification
Two functions fall in the same cycle: closing a word and starting the next one. On the final bit cycle, the combinational result must use the old flag, while the flag itself is cleared rather than toggled. The bench provokes this with a final bit of 1 followed straight away by a new word, and with words of all ones. It then judges the result, and the first result of the following word, against a reference model that counts ones per word. Resets dropped in the middle of a word also exercise restarting the framing on the very next bit.

// File: rtl/wpi_pkg.sv
package wpi_pkg;

    typedef enum logic {
        BR_EVEN = 1'b0,
        BR_ODD  = 1'b1
    } parity_branch_e;

endpackage

// File: rtl/wpi_gray_pos.sv
module wpi_gray_pos #(
    parameter int WORD_LEN = 4
) (
    input  logic clk_i,
    input  logic rst_i,
    output logic last_o,
    output logic first_o
);
    localparam int CW = (WORD_LEN > 2) ? $clog2(WORD_LEN) : 1;
    localparam logic [CW-1:0] LAST_BIN = CW'(WORD_LEN - 1);

    function automatic logic [CW-1:0] to_gray(input logic [CW-1:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [CW-1:0] from_gray(input logic [CW-1:0] g);
        logic [CW-1:0] b;
        b[CW-1] = g[CW-1];
        for (int i = CW - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

    localparam logic [CW-1:0] LAST_CODE = to_gray(LAST_BIN);

    logic [CW-1:0] pos_q;
    logic [CW-1:0] pos_d;
    logic [CW-1:0] bin_now;

    always_comb begin
        bin_now = from_gray(pos_q);
        if (bin_now == LAST_BIN) begin
            pos_d = '0;
        end else begin
            pos_d = to_gray(bin_now + CW'(1));
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            pos_q <= '0;
        end else begin
            pos_q <= pos_d;
        end
    end

    assign last_o  = (pos_q == LAST_CODE);
    assign first_o = (pos_q == '0);

    // R6
    gray_step_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        1'b1 |=> ($countones(pos_q ^ $past(pos_q)) == 1));

endmodule

// File: rtl/wpi_parity_track.sv
module wpi_parity_track
    import wpi_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic bit_i,
    input  logic last_i,
    input  logic first_i,
    output logic odd_o
);
    parity_branch_e br_q;
    parity_branch_e br_d;

    always_comb begin
        br_d = br_q;
        unique case (br_q)
            BR_EVEN: begin
                if (last_i)     br_d = BR_EVEN;
                else if (bit_i) br_d = BR_ODD;
                else            br_d = BR_EVEN;
            end
            BR_ODD: begin
                if (last_i)     br_d = BR_EVEN;
                else if (bit_i) br_d = BR_EVEN;
                else            br_d = BR_ODD;
            end
            default: br_d = BR_EVEN;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            br_q <= BR_EVEN;
        end else begin
            br_q <= br_d;
        end
    end

    assign odd_o = (br_q == BR_ODD);

    // R5
    word_start_even_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        first_i |-> (br_q == BR_EVEN));

    // R5
    close_clears_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        last_i |=> !odd_o);

endmodule

// File: rtl/wpi_result.sv
module wpi_result (
    input  logic clk_i,
    input  logic rst_i,
    input  logic bit_i,
    input  logic last_i,
    input  logic odd_i,
    output logic parity_o,
    output logic valid_o
);
    always_comb begin
        valid_o  = last_i;
        parity_o = 1'b0;
        if (last_i) begin
            parity_o = bit_i ^ odd_i;
        end
    end

    // R2
    single_strobe_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        valid_o |=> !valid_o);

    // R4
    quiet_output_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !last_i |-> !parity_o);

endmodule

// File: rtl/wpi_serial_parity.sv
module wpi_serial_parity #(
    parameter int WORD_LEN = 4
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic bit_i,
    output logic parity_o,
    output logic valid_o
);
    logic last_w;
    logic first_w;
    logic odd_w;

    wpi_gray_pos #(.WORD_LEN(WORD_LEN)) u_pos (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .last_o  (last_w),
        .first_o (first_w)
    );

    wpi_parity_track u_track (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .bit_i   (bit_i),
        .last_i  (last_w),
        .first_i (first_w),
        .odd_o   (odd_w)
    );

    wpi_result u_res (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .bit_i    (bit_i),
        .last_i   (last_w),
        .odd_i    (odd_w),
        .parity_o (parity_o),
        .valid_o  (valid_o)
    );

endmodule

// File: tb/sim_wpi_serial_parity.sv
module sim_wpi_serial_parity;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst = 1'b1;
    logic din = 1'b0;
    logic p4, v4, p8, v8;

    wpi_serial_parity #(.WORD_LEN(4)) u0 (
        .clk_i(clk), .rst_i(rst), .bit_i(din), .parity_o(p4), .valid_o(v4)
    );
    wpi_serial_parity #(.WORD_LEN(8)) u1 (
        .clk_i(clk), .rst_i(rst), .bit_i(din), .parity_o(p8), .valid_o(v8)
    );

    int checks = 0;
    int errors = 0;
    int pos4 = 0, ones4 = 0, pos8 = 0, ones8 = 0;
    bit prev_rst = 1'b0;
    string tag = "R3";
    bit done = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input bit b, input bit r);
        int ev;
        int ep;
        @(negedge clk);
        din = b;
        rst = r;
        #1;
        if (r) begin
            if (prev_rst) begin
                chk(v4 == 1'b0 && p4 == 1'b0, "R1", {v4, p4}, 0);
                chk(v8 == 1'b0 && p8 == 1'b0, "R1", {v8, p8}, 0);
            end
            pos4 = 0; ones4 = 0; pos8 = 0; ones8 = 0;
        end else begin
            ev = (pos4 == 3) ? 1 : 0;
            ep = ev ? ((ones4 + b) % 2) : 0;
            chk(v4 == ev[0], "R2 R6", v4, ev);
            if (ev != 0) chk(p4 == ep[0], tag, p4, ep);
            else         chk(p4 == 1'b0, "R4", p4, 0);
            ev = (pos8 == 7) ? 1 : 0;
            ep = ev ? ((ones8 + b) % 2) : 0;
            chk(v8 == ev[0], "R8 valid", v8, ev);
            chk(p8 == ep[0], "R8 parity", p8, ep);
            if (pos4 == 3) begin pos4 = 0; ones4 = 0; end
            else begin pos4++; ones4 += b; end
            if (pos8 == 7) begin pos8 = 0; ones8 = 0; end
            else begin pos8++; ones8 += b; end
        end
        prev_rst = r;
    endtask

    task automatic word4(input logic [3:0] w);
        for (int i = 3; i >= 0; i--) step(w[i], 1'b0);
    endtask

    initial begin
        step(1'b0, 1'b1);
        step(1'b1, 1'b1);
        step(1'b1, 1'b1);
        tag = "R3";
        word4(4'b1011);
        word4(4'b0000);
        word4(4'b1111);
        word4(4'b0110);
        tag = "R5";
        word4(4'b0001);
        word4(4'b0001);
        word4(4'b1111);
        word4(4'b0000);
        tag = "R7";
        word4(4'b1000);
        word4(4'b0100);
        word4(4'b0010);
        word4(4'b0001);
        word4(4'b1100);
        word4(4'b0011);
        word4(4'b1010);
        word4(4'b0111);
        word4(4'b1110);
        tag = "R9";
        step(1'b1, 1'b0);
        step(1'b1, 1'b0);
        step(1'b0, 1'b1);
        word4(4'b1101);
        word4(4'b1001);
        step(1'b1, 1'b0);
        step(1'b1, 1'b1);
        step(1'b1, 1'b1);
        word4(4'b0100);
        tag = "R3";
        for (int k = 0; k < 200; k++) step(1'($urandom_range(0, 1)), 1'b0);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                errors++;
                $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule